// File: doc/BRIEF.md
# AXI4 Burst Memory Slave with Unaligned Start Addresses

This block is a memory target on an AXI4 port. It serves incrementing read and write bursts from an internal RAM that is one data word wide. Every beat is a full-width transfer. Read and write requests each enter their own small queue. Each direction serves its queue strictly in order and runs independently of the other direction. The word index of a burst advances by one per beat and wraps at the end of the memory.

A static mode input, `unaligned_en`, sets how start addresses that are not a multiple of the word size are handled.

- With the mode on, a read beat is assembled from two neighbouring words. A write beat is spread over two neighbouring words, with its bytes and strobes shifted by the byte offset of the start address. The effect is that byte k of beat i always maps to byte address start + i·BPW + k, where BPW is the number of bytes per word.
- With the mode off, a misaligned request is refused with an error response. Its write data is still consumed.

A registered pulse flags write-data beats whose last marker or ID disagrees with the burst being served.

Top module: `axi_burst_ram`

## Requirements
- R1: A burst with length field L moves exactly L+1 beats. On the read side, `r_last` is 1 on beat L only.
- R2: An aligned read returns the stored words in ascending order, starting at word addr/BPW. The word index wraps modulo the memory depth.
- R3: With `unaligned_en`=1, byte k of read beat i equals the memory byte at address (addr + i·BPW + k) modulo the memory size, for any start address.
- R4: Each read beat of an accepted well-formed request carries the request ID and response code 2'b00 (OKAY).
- R5: A write beat changes only the bytes whose strobe bit is 1. A beat with an all-zero strobe leaves memory unchanged.
- R6: With `unaligned_en`=1, byte k of write beat i, when strobed, lands at byte address (addr + i·BPW + k) modulo the memory size. This splits the beat over two adjacent words.
- R7: Each write burst gets exactly one response, raised in the cycle after its final data beat. The response carries the burst ID and code 2'b00, and `b_valid` stays high until `b_ready`.
- R8: A data beat whose `w_last` differs from "this is beat L", or whose `w_id` differs from the burst ID, raises `w_proto_err` for one cycle, in the cycle after that beat. The burst length is still taken from `aw_len`, and the data is still written.
- R9: With `unaligned_en`=0, a misaligned request is refused as follows. A read returns L+1 beats with code 2'b10 (SLVERR) and zero data. A write has its beats drained without touching memory, and it receives one 2'b10 response.
- R10: Requests are served in arrival order. With the read data channel stalled and bursts of two or more beats, exactly FIFO_DEPTH+1 read requests are accepted before `ar_ready` drops.
- R11: While `r_valid`=1 and `r_ready`=0, the read beat payload holds stable.
- R12: After reset, `r_valid`, `b_valid` and `w_proto_err` are 0, `ar_ready` and `aw_ready` are 1, and every memory byte reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unaligned_en | input | 1 | Allows misaligned start addresses; sampled when a request starts service |
| aw_valid | input | 1 | Write request valid |
| aw_ready | output | 1 | Write request queue has room |
| aw_id | input | ID_W | Write burst ID |
| aw_addr | input | ADDR_W | Write start byte address |
| aw_len | input | LEN_W | Write beats minus one |
| w_valid | input | 1 | Write beat valid |
| w_ready | output | 1 | Write beat accepted |
| w_id | input | ID_W | Write beat ID, compared with the burst ID |
| w_data | input | DATA_W | Write beat data |
| w_strb | input | DATA_W/8 | Write byte enables |
| w_last | input | 1 | Marks the final write beat |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response taken |
| b_id | output | ID_W | Write response ID |
| b_resp | output | 2 | Write response code |
| ar_valid | input | 1 | Read request valid |
| ar_ready | output | 1 | Read request queue has room |
| ar_id | input | ID_W | Read burst ID |
| ar_addr | input | ADDR_W | Read start byte address |
| ar_len | input | LEN_W | Read beats minus one |
| r_valid | output | 1 | Read beat valid |
| r_ready | input | 1 | Read beat taken |
| r_id | output | ID_W | Read beat ID |
| r_data | output | DATA_W | Read beat data |
| r_resp | output | 2 | Read beat response code |
| r_last | output | 1 | Marks the final read beat |
| w_proto_err | output | 1 | One-cycle flag for a bad last marker or write ID |

## Verification
Timing of each result:
- The write response rises in the cycle after the handshake of the final data beat. The bench therefore tests `b_valid` at the first falling edge after that beat, and tests it again after the response is taken to confirm there is only one.
- The protocol-error pulse also appears one cycle after the offending beat. A falling-edge monitor counts these pulses and compares the total with the number of faulty beats that were sent.
- Read beats have no fixed delay: the first beat follows an idle engine's request handshake by two cycles. The bench therefore judges a read beat only at a falling edge where both `r_valid` and its own `r_ready` are high, and for every beat compares the payload held across stalled cycles.

// File: rtl/axi_burst_ram_pkg.sv
package axi_burst_ram_pkg;

  typedef enum logic [1:0] {
    RESP_OKAY   = 2'b00,
    RESP_SLVERR = 2'b10
  } resp_e;

  // true when a start address violates the current alignment policy
  function automatic logic misaligned_refused(input logic allow, input logic nonzero_off);
    return !allow && nonzero_off;
  endfunction

endpackage

// File: rtl/abr_req_fifo.sv
module abr_req_fifo #(
  parameter int W     = 20,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] slot [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;
  logic          do_push, do_pop;

  assign full     = (cnt == (PW+1)'(DEPTH));
  assign empty    = (cnt == '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign pop_data = slot[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) begin
        slot[wp] <= push_data;
        wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + PW'(1);
      end
      if (do_pop) rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + PW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + (PW+1)'(1);
        2'b01:   cnt <= cnt - (PW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/abr_store.sv
module abr_store #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [DATA_W-1:0]   rd_lo,
  output logic [DATA_W-1:0]   rd_hi,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DATA_W-1:0]   wr_lo_data,
  input  logic [DATA_W/8-1:0] wr_lo_strb,
  input  logic [DATA_W-1:0]   wr_hi_data,
  input  logic [DATA_W/8-1:0] wr_hi_strb
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int NB    = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  rd_nxt, wr_nxt;

  assign rd_nxt = rd_idx + IDX_W'(1);
  assign wr_nxt = wr_idx + IDX_W'(1);
  assign rd_lo  = mem[rd_idx];
  assign rd_hi  = mem[rd_nxt];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      for (int j = 0; j < NB; j++) begin
        if (wr_lo_strb[j]) mem[wr_idx][j*8 +: 8] <= wr_lo_data[j*8 +: 8];
        if (wr_hi_strb[j]) mem[wr_nxt][j*8 +: 8] <= wr_hi_data[j*8 +: 8];
      end
    end
  end
endmodule

// File: rtl/abr_read_eng.sv
module abr_read_eng
  import axi_burst_ram_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unaligned_en,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_pop,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_lo,
  input  logic [DATA_W-1:0] rd_hi,
  output logic              r_valid,
  input  logic              r_ready,
  output logic [ID_W-1:0]   r_id,
  output logic [DATA_W-1:0] r_data,
  output logic [1:0]        r_resp,
  output logic              r_last,
  output logic              ev_issue,
  output logic              ev_issue_last,
  output logic [LEN_W-1:0]  cur_len
);
  // word pair -> beat: drop 'off' low bytes, fill from the upper neighbour
  function automatic logic [DATA_W-1:0] join_beat(input logic [DATA_W-1:0] lo,
                                                  input logic [DATA_W-1:0] hi,
                                                  input logic [OFF_W-1:0]  off);
    logic [2*DATA_W-1:0] pair;
    pair = {hi, lo} >> {off, 3'b000};
    return pair[DATA_W-1:0];
  endfunction

  logic              act, err;
  logic [LEN_W-1:0]  cnt, len;
  logic [IDX_W-1:0]  base;
  logic [OFF_W-1:0]  off;
  logic [ID_W-1:0]   id;
  logic              rv_q, rl_q;
  logic [DATA_W-1:0] rd_q;
  logic [ID_W-1:0]   ri_q;
  resp_e             rr_q;

  assign req_pop       = !act && req_valid;
  assign ev_issue      = act && (!rv_q || r_ready);
  assign ev_issue_last = ev_issue && (cnt == len);
  assign cur_len       = len;
  assign rd_idx        = base + IDX_W'(cnt);

  assign r_valid = rv_q;
  assign r_data  = rd_q;
  assign r_id    = ri_q;
  assign r_resp  = rr_q;
  assign r_last  = rl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      err  <= 1'b0;
      cnt  <= '0;
      len  <= '0;
      base <= '0;
      off  <= '0;
      id   <= '0;
      rv_q <= 1'b0;
      rl_q <= 1'b0;
      rd_q <= '0;
      ri_q <= '0;
      rr_q <= RESP_OKAY;
    end else begin
      if (req_pop) begin
        act  <= 1'b1;
        cnt  <= '0;
        len  <= req_len;
        base <= req_addr[ADDR_W-1:OFF_W];
        off  <= req_addr[OFF_W-1:0];
        id   <= req_id;
        err  <= misaligned_refused(unaligned_en, req_addr[OFF_W-1:0] != '0);
      end
      if (ev_issue) begin
        rv_q <= 1'b1;
        rd_q <= err ? '0 : join_beat(rd_lo, rd_hi, off);
        rl_q <= (cnt == len);
        ri_q <= id;
        rr_q <= err ? RESP_SLVERR : RESP_OKAY;
        if (cnt == len) act <= 1'b0;
        else            cnt <= cnt + LEN_W'(1);
      end else if (rv_q && r_ready) begin
        rv_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/abr_write_eng.sv
module abr_write_eng
  import axi_burst_ram_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 8,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 2,
  parameter int IDX_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                unaligned_en,
  input  logic                req_valid,
  input  logic [ID_W-1:0]     req_id,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LEN_W-1:0]    req_len,
  output logic                req_pop,
  input  logic                w_valid,
  output logic                w_ready,
  input  logic [ID_W-1:0]     w_id,
  input  logic [DATA_W-1:0]   w_data,
  input  logic [DATA_W/8-1:0] w_strb,
  input  logic                w_last,
  output logic                b_valid,
  input  logic                b_ready,
  output logic [ID_W-1:0]     b_id,
  output logic [1:0]          b_resp,
  output logic                wr_en,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [DATA_W-1:0]   wr_lo_data,
  output logic [DATA_W/8-1:0] wr_lo_strb,
  output logic [DATA_W-1:0]   wr_hi_data,
  output logic [DATA_W/8-1:0] wr_hi_strb,
  output logic                proto_err,
  output logic                ev_beat
);
  localparam int NB = DATA_W / 8;

  // beat -> word pair: lift data by 'off' bytes, spill the top into the next word
  function automatic logic [2*DATA_W-1:0] spread_data(input logic [DATA_W-1:0] d,
                                                      input logic [OFF_W-1:0]  off);
    return {{DATA_W{1'b0}}, d} << {off, 3'b000};
  endfunction

  function automatic logic [2*NB-1:0] spread_strb(input logic [NB-1:0]    s,
                                                  input logic [OFF_W-1:0] off);
    return {{NB{1'b0}}, s} << off;
  endfunction

  logic              act, err, final_beat;
  logic [LEN_W-1:0]  cnt, len;
  logic [IDX_W-1:0]  base;
  logic [OFF_W-1:0]  off;
  logic [ID_W-1:0]   id;
  logic              bv_q, pe_q;
  logic [ID_W-1:0]   bi_q;
  resp_e             br_q;
  logic [2*DATA_W-1:0] pair_d;
  logic [2*NB-1:0]     pair_s;

  assign req_pop    = !act && !bv_q && req_valid;
  assign w_ready    = act;
  assign ev_beat    = w_valid && act;
  assign final_beat = (cnt == len);

  assign pair_d     = spread_data(w_data, off);
  assign pair_s     = spread_strb(w_strb, off);
  assign wr_en      = ev_beat && !err;
  assign wr_idx     = base + IDX_W'(cnt);
  assign wr_lo_data = pair_d[DATA_W-1:0];
  assign wr_hi_data = pair_d[2*DATA_W-1:DATA_W];
  assign wr_lo_strb = pair_s[NB-1:0];
  assign wr_hi_strb = pair_s[2*NB-1:NB];

  assign b_valid   = bv_q;
  assign b_id      = bi_q;
  assign b_resp    = br_q;
  assign proto_err = pe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      err  <= 1'b0;
      cnt  <= '0;
      len  <= '0;
      base <= '0;
      off  <= '0;
      id   <= '0;
      bv_q <= 1'b0;
      bi_q <= '0;
      br_q <= RESP_OKAY;
      pe_q <= 1'b0;
    end else begin
      pe_q <= ev_beat && ((w_last != final_beat) || (w_id != id));
      if (req_pop) begin
        act  <= 1'b1;
        cnt  <= '0;
        len  <= req_len;
        base <= req_addr[ADDR_W-1:OFF_W];
        off  <= req_addr[OFF_W-1:0];
        id   <= req_id;
        err  <= misaligned_refused(unaligned_en, req_addr[OFF_W-1:0] != '0);
      end
      if (ev_beat) begin
        if (final_beat) begin
          act  <= 1'b0;
          bv_q <= 1'b1;
          bi_q <= id;
          br_q <= err ? RESP_SLVERR : RESP_OKAY;
        end else begin
          cnt <= cnt + LEN_W'(1);
        end
      end else if (bv_q && b_ready) begin
        bv_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/axi_burst_ram.sv
module axi_burst_ram #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int ID_W       = 4,
  parameter int LEN_W      = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                unaligned_en,
  input  logic                aw_valid,
  output logic                aw_ready,
  input  logic [ID_W-1:0]     aw_id,
  input  logic [ADDR_W-1:0]   aw_addr,
  input  logic [LEN_W-1:0]    aw_len,
  input  logic                w_valid,
  output logic                w_ready,
  input  logic [ID_W-1:0]     w_id,
  input  logic [DATA_W-1:0]   w_data,
  input  logic [DATA_W/8-1:0] w_strb,
  input  logic                w_last,
  output logic                b_valid,
  input  logic                b_ready,
  output logic [ID_W-1:0]     b_id,
  output logic [1:0]          b_resp,
  input  logic                ar_valid,
  output logic                ar_ready,
  input  logic [ID_W-1:0]     ar_id,
  input  logic [ADDR_W-1:0]   ar_addr,
  input  logic [LEN_W-1:0]    ar_len,
  output logic                r_valid,
  input  logic                r_ready,
  output logic [ID_W-1:0]     r_id,
  output logic [DATA_W-1:0]   r_data,
  output logic [1:0]          r_resp,
  output logic                r_last,
  output logic                w_proto_err
);
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);
  localparam int IDX_W = ADDR_W - OFF_W;
  localparam int REQ_W = ID_W + ADDR_W + LEN_W;

  // read request path
  logic             arq_full, arq_empty, arq_pop;
  logic [REQ_W-1:0] arq_out;
  logic [ID_W-1:0]  arq_id;
  logic [ADDR_W-1:0] arq_addr;
  logic [LEN_W-1:0] arq_len;

  // write request path
  logic             awq_full, awq_empty, awq_pop;
  logic [REQ_W-1:0] awq_out;
  logic [ID_W-1:0]  awq_id;
  logic [ADDR_W-1:0] awq_addr;
  logic [LEN_W-1:0] awq_len;

  // store ports
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [DATA_W-1:0] rd_lo, rd_hi, wr_lo_data, wr_hi_data;
  logic [NB-1:0]     wr_lo_strb, wr_hi_strb;
  logic              wr_en;

  // named events for the checker
  logic              rd_issue, rd_issue_last, wr_beat;
  logic [LEN_W-1:0]  rd_cur_len;

  assign ar_ready = !arq_full;
  assign aw_ready = !awq_full;
  assign {arq_id, arq_addr, arq_len} = arq_out;
  assign {awq_id, awq_addr, awq_len} = awq_out;

  abr_req_fifo #(.W(REQ_W), .DEPTH(FIFO_DEPTH)) u_arq (
    .clk(clk), .rst_n(rst_n),
    .push(ar_valid), .push_data({ar_id, ar_addr, ar_len}), .full(arq_full),
    .pop(arq_pop), .pop_data(arq_out), .empty(arq_empty)
  );

  abr_req_fifo #(.W(REQ_W), .DEPTH(FIFO_DEPTH)) u_awq (
    .clk(clk), .rst_n(rst_n),
    .push(aw_valid), .push_data({aw_id, aw_addr, aw_len}), .full(awq_full),
    .pop(awq_pop), .pop_data(awq_out), .empty(awq_empty)
  );

  abr_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(rd_idx), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_lo_data(wr_lo_data), .wr_lo_strb(wr_lo_strb),
    .wr_hi_data(wr_hi_data), .wr_hi_strb(wr_hi_strb)
  );

  abr_read_eng #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
  ) u_rd (
    .clk(clk), .rst_n(rst_n), .unaligned_en(unaligned_en),
    .req_valid(!arq_empty), .req_id(arq_id), .req_addr(arq_addr), .req_len(arq_len),
    .req_pop(arq_pop),
    .rd_idx(rd_idx), .rd_lo(rd_lo), .rd_hi(rd_hi),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data),
    .r_resp(r_resp), .r_last(r_last),
    .ev_issue(rd_issue), .ev_issue_last(rd_issue_last), .cur_len(rd_cur_len)
  );

  abr_write_eng #(
    .ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .DATA_W(DATA_W), .OFF_W(OFF_W), .IDX_W(IDX_W)
  ) u_wr (
    .clk(clk), .rst_n(rst_n), .unaligned_en(unaligned_en),
    .req_valid(!awq_empty), .req_id(awq_id), .req_addr(awq_addr), .req_len(awq_len),
    .req_pop(awq_pop),
    .w_valid(w_valid), .w_ready(w_ready), .w_id(w_id), .w_data(w_data),
    .w_strb(w_strb), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
    .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_lo_data(wr_lo_data), .wr_lo_strb(wr_lo_strb),
    .wr_hi_data(wr_hi_data), .wr_hi_strb(wr_hi_strb),
    .proto_err(w_proto_err), .ev_beat(wr_beat)
  );
endmodule

// File: rtl/abr_checker.sv
module abr_checker #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              r_valid,
  input logic              r_ready,
  input logic [DATA_W-1:0] r_data,
  input logic [ID_W-1:0]   r_id,
  input logic [1:0]        r_resp,
  input logic              r_last,
  input logic              b_valid,
  input logic              b_ready,
  input logic [ID_W-1:0]   b_id,
  input logic              w_valid,
  input logic              w_ready,
  input logic              w_proto_err,
  input logic              rd_issue,
  input logic              rd_issue_last,
  input logic [LEN_W-1:0]  rd_cur_len
);
  // independent count of read beats issued within the current burst
  logic [LEN_W-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             seen <= '0;
    else if (rd_issue_last) seen <= '0;
    else if (rd_issue)      seen <= seen + LEN_W'(1);
  end

  // R1: the final beat is issued exactly after len earlier beats
  a_r1_last_on_final: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue_last |-> seen == rd_cur_len);

  // R11: stalled read beat keeps its payload
  a_r11_rbeat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data) && $stable(r_id)
                               && $stable(r_last) && $stable(r_resp)));

  // R7: write response held until taken
  a_r7_bresp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && !b_ready) |=> (b_valid && $stable(b_id)));

  // R7: a response only rises after a data beat
  a_r7_bresp_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_valid) |-> $past(w_valid && w_ready));

  // R8: error pulse only follows a data beat
  a_r8_err_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    w_proto_err |-> $past(w_valid && w_ready));

  // R9: refused reads carry no data
  a_r9_refused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && r_resp == 2'b10) |-> r_data == '0);
endmodule

bind axi_burst_ram abr_checker #(.DATA_W(DATA_W), .ID_W(ID_W), .LEN_W(LEN_W)) u_abr_checker (
  .clk(clk), .rst_n(rst_n),
  .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_id(r_id),
  .r_resp(r_resp), .r_last(r_last),
  .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id),
  .w_valid(w_valid), .w_ready(w_ready), .w_proto_err(w_proto_err),
  .rd_issue(rd_issue), .rd_issue_last(rd_issue_last), .rd_cur_len(rd_cur_len)
);

// File: tb/axi_burst_ram_bench.sv
module axi_burst_ram_bench;
  localparam int DW = 32, AW = 8, IW = 4, LW = 8, QD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic unaligned_en = 1'b1;
  logic aw_valid = 0, aw_ready;
  logic [IW-1:0] aw_id = '0;
  logic [AW-1:0] aw_addr = '0;
  logic [LW-1:0] aw_len = '0;
  logic w_valid = 0, w_ready, w_last = 0;
  logic [IW-1:0] w_id = '0;
  logic [DW-1:0] w_data = '0;
  logic [3:0] w_strb = '0;
  logic b_valid, b_ready = 0;
  logic [IW-1:0] b_id;
  logic [1:0] b_resp;
  logic ar_valid = 0, ar_ready;
  logic [IW-1:0] ar_id = '0;
  logic [AW-1:0] ar_addr = '0;
  logic [LW-1:0] ar_len = '0;
  logic r_valid, r_ready = 0, r_last;
  logic [IW-1:0] r_id;
  logic [DW-1:0] r_data;
  logic [1:0] r_resp;
  logic w_proto_err;

  int n_chk = 0, n_err = 0, perr_cnt = 0;
  logic [7:0] mdl [256];

  always #4 clk = ~clk;  // 125 MHz

  axi_burst_ram #(.DATA_W(DW), .ADDR_W(AW), .ID_W(IW), .LEN_W(LW), .FIFO_DEPTH(QD)) u_axi_burst_ram (
    .clk(clk), .rst_n(rst_n), .unaligned_en(unaligned_en),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_addr(aw_addr), .aw_len(aw_len),
    .w_valid(w_valid), .w_ready(w_ready), .w_id(w_id), .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr), .ar_len(ar_len),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data), .r_resp(r_resp), .r_last(r_last),
    .w_proto_err(w_proto_err)
  );

  always @(negedge clk) if (rst_n && w_proto_err) perr_cnt++;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word(input logic [7:0] addr, input int i);
    logic [31:0] v;
    for (int k = 0; k < 4; k++) v[k*8 +: 8] = mdl[8'(int'(addr) + i*4 + k)];
    return v;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // strobe mode: 0 full, 1 random, 2 zero
  task automatic do_write(input logic [3:0] id, input logic [7:0] addr, input int len,
                          input int smode, input int bad_last, input bit bad_id,
                          input bit exp_err, input string tag);
    logic [31:0] d;
    logic [3:0] s;
    int dly;
    @(negedge clk);
    aw_valid = 1; aw_id = id; aw_addr = addr; aw_len = 8'(len);
    while (!aw_ready) @(negedge clk);
    @(negedge clk);
    aw_valid = 0;
    for (int i = 0; i <= len; i++) begin
      d = $urandom;
      s = (smode == 0) ? 4'hF : (smode == 1) ? 4'($urandom) : 4'h0;
      w_valid = 1; w_data = d; w_strb = s;
      w_last = (i == len) ^ (i == bad_last);
      w_id = bad_id ? ~id : id;
      while (!w_ready) @(negedge clk);
      @(negedge clk);
      if (!exp_err)
        for (int k = 0; k < 4; k++) if (s[k]) mdl[8'(int'(addr) + i*4 + k)] = d[k*8 +: 8];
    end
    w_valid = 0; w_last = 0;
    chk(b_valid === 1'b1, "R7", "b_valid in cycle after final beat", 64'(b_valid), 1);
    dly = $urandom % 3;
    repeat (dly) @(negedge clk);
    chk(b_valid === 1'b1, "R7", "b_valid held", 64'(b_valid), 1);
    chk(b_id == id, "R7", "b_id", 64'(b_id), 64'(id));
    chk(b_resp == (exp_err ? 2'b10 : 2'b00), exp_err ? "R9" : tag, "b_resp", 64'(b_resp),
        exp_err ? 64'd2 : 64'd0);
    b_ready = 1;
    @(negedge clk);
    b_ready = 0;
    chk(b_valid == 1'b0, "R7", "single response", 64'(b_valid), 0);
  endtask

  task automatic send_ar(input logic [3:0] id, input logic [7:0] addr, input int len,
                         input int limit, output bit ok);
    @(negedge clk);
    ar_valid = 1; ar_id = id; ar_addr = addr; ar_len = 8'(len);
    ok = 0;
    for (int c = 0; c < limit; c++) begin
      if (ar_ready) begin ok = 1; break; end
      @(negedge clk);
    end
    if (ok) @(negedge clk);
    ar_valid = 0;
  endtask

  task automatic collect(input logic [3:0] id, input logic [7:0] addr, input int len,
                         input bit exp_err, input string tag);
    int i;
    bit stall, rdy;
    logic [31:0] hold, exp;
    i = 0; stall = 0; hold = '0;
    while (i <= len) begin
      rdy = ($urandom % 4) != 0;
      r_ready = rdy;
      if (r_valid && stall) chk(r_data == hold, "R11", "payload held under stall", 64'(r_data), 64'(hold));
      if (r_valid && rdy) begin
        exp = exp_err ? 32'h0 : model_word(addr, i);
        chk(r_data == exp, exp_err ? "R9" : tag, "read beat data", 64'(r_data), 64'(exp));
        chk(r_id == id, "R4", "read beat id", 64'(r_id), 64'(id));
        chk(r_resp == (exp_err ? 2'b10 : 2'b00), exp_err ? "R9" : "R4", "read beat resp",
            64'(r_resp), exp_err ? 64'd2 : 64'd0);
        chk(r_last == (i == len), "R1", "r_last position", 64'(r_last), 64'(i == len));
        i++;
      end
      stall = r_valid && !rdy;
      hold = r_data;
      @(negedge clk);
    end
    r_ready = 0;
  endtask

  task automatic do_read(input logic [3:0] id, input logic [7:0] addr, input int len,
                         input bit exp_err, input string tag);
    bit ok;
    send_ar(id, addr, len, 1000, ok);
    chk(ok, "R10", "read request accepted", 64'(ok), 1);
    collect(id, addr, len, exp_err, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int acc, base;
    bit ok;
    void'($urandom(32'd20240611));
    for (int a = 0; a < 256; a++) mdl[a] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12: reset state
    chk(r_valid == 0, "R12", "r_valid after reset", 64'(r_valid), 0);
    chk(b_valid == 0, "R12", "b_valid after reset", 64'(b_valid), 0);
    chk(w_proto_err == 0, "R12", "w_proto_err after reset", 64'(w_proto_err), 0);
    chk(ar_ready == 1, "R12", "ar_ready after reset", 64'(ar_ready), 1);
    chk(aw_ready == 1, "R12", "aw_ready after reset", 64'(aw_ready), 1);
    do_read(4'h1, 8'h40, 3, 0, "R12");

    // R2: aligned burst and index wrap
    do_write(4'h2, 8'h00, 7, 0, -1, 0, 0, "R2");
    do_read(4'h3, 8'h00, 7, 0, "R2");
    do_write(4'h4, 8'hF8, 3, 0, -1, 0, 0, "R2");
    do_read(4'h5, 8'hF8, 3, 0, "R2");

    // R6 / R3: unaligned split and join
    do_write(4'h6, 8'h13, 4, 0, -1, 0, 0, "R6");
    do_read(4'h7, 8'h10, 5, 0, "R6");
    do_read(4'h8, 8'h11, 3, 0, "R3");
    do_read(4'h9, 8'hFE, 2, 0, "R3");

    // R5: partial and zero strobes
    do_write(4'hA, 8'h00, 3, 1, -1, 0, 0, "R5");
    do_write(4'hB, 8'h04, 1, 2, -1, 0, 0, "R5");
    do_read(4'hC, 8'h00, 3, 0, "R5");

    // R9: refused misaligned requests
    unaligned_en = 0;
    do_read(4'hD, 8'h21, 2, 1, "R9");
    do_write(4'hE, 8'h05, 1, 0, -1, 0, 1, "R9");
    do_read(4'hF, 8'h04, 2, 0, "R9");
    unaligned_en = 1;

    // R8: bad last marker, bad write id
    base = perr_cnt;
    do_write(4'h5, 8'h30, 2, 0, 1, 0, 0, "R8");
    do_write(4'h6, 8'h50, 0, 0, -1, 1, 0, "R8");
    repeat (2) @(negedge clk);
    chk(perr_cnt - base == 2, "R8", "error pulses", 64'(perr_cnt - base), 2);
    do_read(4'h1, 8'h30, 2, 0, "R8");
    do_read(4'h2, 8'h50, 0, 0, "R8");

    // R10: queue depth and ordering with the read channel stalled
    r_ready = 0;
    acc = 0;
    for (int n = 1; n <= QD + 2; n++) begin
      send_ar(4'(n), 8'(n * 16), 1, 10, ok);
      if (ok) acc++;
    end
    chk(acc == QD + 1, "R10", "requests accepted while stalled", 64'(acc), 64'(QD + 1));
    for (int n = 1; n <= QD + 1; n++) collect(4'(n), 8'(n * 16), 1, 0, "R10");

    // random mix
    for (int t = 0; t < 40; t++) begin
      logic [7:0] ad;
      int ln;
      ad = 8'($urandom);
      ln = $urandom % 6;
      if ($urandom % 2) do_write(4'($urandom), ad, ln, 1, -1, 0, 0, "R6");
      else              do_read(4'($urandom), ad, ln, 0, "R3");
    end

    repeat (2) @(negedge clk);
    chk(perr_cnt == 2, "R8", "no spurious error pulses", 64'(perr_cnt), 2);
    finish_run();
  end
endmodule